// File: doc/BRIEF.md
# Downstream Port Power Controller

This block owns the power-enable outputs of a hub's downstream ports, one per port, active high. Each port has an active-low over-current sense input. The block brings that input into the clock domain and qualifies it against a programmable run length. A qualified fault turns the port's power off and records the event in a sticky status bit and a change bit. The host clears both bits with a command.

A port marked for charging powers up on the rising edge of the configuration-complete flag. It does not wait for enumeration. A port's charge marking comes from a register bit, and port 0 can also take it from a strap pin. A fault seen while the hub is not enumerated locks the port out of automatic restore. Only a host set-power command or a hardware reset brings its power back.

Both the hardware reset and the USB bus reset put charging ports in the powered state and all other ports in the unpowered state. Once the hub is enumerated, only host commands move the power state.

Top module: `port_power_ctrl`

## Requirements
- R1: While not enumerated, a rising edge of `cfg_done` turns on the power of every charging port that is not locked out, on the next clock edge. No enumeration or VBUS input is involved.
- R2: When `oc_n` of a port has been low for the qualification run, that port's `pwr_en` goes low. Only that port is affected; no other port changes.
- R3: A fault qualified while `enumerated` is low locks the port. A later `cfg_done` rising edge or bus reset does not restore its power. A host set-power command does restore it.
- R4: While `rst_n` is low, `pwr_en` equals the port's charge marking. After release, the lockout, status and change bits are 0.
- R5: A one-cycle `bus_reset` sets `pwr_en` to the charge marking of each port, except that locked ports stay off.
- R6: Bit i of `chg_cfg` marks port i for charging. Port 0 is also marked when `chg_strap0` is high.
- R7: Host `host_set_pwr[i]` turns port i on at the next edge. `host_clr_pwr[i]` turns it off. Clear wins when both are given in the same cycle.
- R8: A low pulse on `oc_n` that, after the two-flop synchronizer, is shorter than `oc_qual` cycles does not affect power or status. An `oc_qual` of 0 acts as 1.
- R9: A qualified fault sets `oc_status`. It also sets `oc_change` when status was clear. `host_clr_oc` clears both when no fault is present.
- R10: While `enumerated` is high, a port's power changes only through host commands, a fault or a bus reset. Changes to `cfg_done` and `chg_cfg` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| bus_reset | input | 1 | USB bus reset pulse |
| chg_cfg | input | NUM_PORTS | Charge marking per port, bit i = port i |
| chg_strap0 | input | 1 | Strap that marks port 0 for charging |
| cfg_done | input | 1 | Configuration complete flag |
| enumerated | input | 1 | Hub is enumerated |
| host_set_pwr | input | NUM_PORTS | Host set-port-power command, one-cycle |
| host_clr_pwr | input | NUM_PORTS | Host clear-port-power command, one-cycle |
| host_clr_oc | input | NUM_PORTS | Host clear of over-current status and change |
| oc_qual | input | CNT_W | Qualification run length in cycles |
| oc_n | input | NUM_PORTS | Over-current sense, active low, asynchronous |
| pwr_en | output | NUM_PORTS | Port power enable, active high |
| oc_status | output | NUM_PORTS | Sticky over-current status |
| oc_change | output | NUM_PORTS | Over-current change flag |

## Verification
The hardest state to reach from the ports is the lockout: a port that faulted before enumeration and must then resist every automatic restore path. The stimulus qualifies a fault with `enumerated` low and releases the sense line. It then replays a configuration edge and a bus reset, checking that power stays off after each. Finally it issues a host set-power command and, separately, a hardware reset. The glitch filter is probed with a pulse one cycle short of the run length, placed right next to a pulse that is long enough.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int CALC_W = 16;

  // Effective run length: a programmed zero behaves as one cycle.
  function automatic logic [CALC_W-1:0] eff_run(input logic [CALC_W-1:0] lim);
    return (lim == '0) ? CALC_W'(1) : lim;
  endfunction

  // The sense line counts as a fault once it has been active for the run.
  function automatic logic run_reached(input logic active,
                                       input logic [CALC_W-1:0] cnt,
                                       input logic [CALC_W-1:0] lim);
    return active && (cnt >= eff_run(lim) - CALC_W'(1));
  endfunction

  // Saturating increment bounded by the effective run.
  function automatic logic [CALC_W-1:0] run_next(input logic active,
                                                 input logic [CALC_W-1:0] cnt,
                                                 input logic [CALC_W-1:0] lim);
    if (!active) return '0;
    if (cnt >= eff_run(lim)) return cnt;
    return cnt + CALC_W'(1);
  endfunction
endpackage

// File: rtl/ppc_oc_filter.sv
module ppc_oc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_n,
  input  logic [CNT_W-1:0] qual,
  output logic             trip
);
  import ppc_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   active;
  logic [CALC_W-1:0]      nxt;

  assign active = sync_q[SYNC_STAGES-1];
  assign nxt    = run_next(active, CALC_W'(run_q), CALC_W'(qual));
  assign trip   = run_reached(active, CALC_W'(run_q), CALC_W'(qual));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ~oc_n};
      run_q  <= nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/ppc_port.sv
module ppc_port (
  input  logic clk,
  input  logic rst_n,
  input  logic charge_en,
  input  logic cfg_rise,
  input  logic enumerated,
  input  logic bus_reset,
  input  logic host_set,
  input  logic host_clr,
  input  logic host_clr_oc,
  input  logic trip,
  output logic pwr_q,
  output logic status_q,
  output logic change_q,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q    <= charge_en;
      status_q <= 1'b0;
      change_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      // power state
      if (trip)                                           pwr_q <= 1'b0;
      else if (bus_reset)                                 pwr_q <= charge_en & ~lock_q;
      else if (host_clr)                                  pwr_q <= 1'b0;
      else if (host_set)                                  pwr_q <= 1'b1;
      else if (cfg_rise && !enumerated && charge_en && !lock_q) pwr_q <= 1'b1;

      // lockout against automatic restore
      if (trip && !enumerated)          lock_q <= 1'b1;
      else if (host_set && !host_clr)   lock_q <= 1'b0;

      // sticky status and change
      if (trip) begin
        status_q <= 1'b1;
        if (!status_q) change_q <= 1'b1;
      end else if (host_clr_oc) begin
        status_q <= 1'b0;
        change_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/port_power_ctrl.sv
module port_power_ctrl #(
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_reset,
  input  logic [NUM_PORTS-1:0] chg_cfg,
  input  logic                 chg_strap0,
  input  logic                 cfg_done,
  input  logic                 enumerated,
  input  logic [NUM_PORTS-1:0] host_set_pwr,
  input  logic [NUM_PORTS-1:0] host_clr_pwr,
  input  logic [NUM_PORTS-1:0] host_clr_oc,
  input  logic [CNT_W-1:0]     oc_qual,
  input  logic [NUM_PORTS-1:0] oc_n,
  output logic [NUM_PORTS-1:0] pwr_en,
  output logic [NUM_PORTS-1:0] oc_status,
  output logic [NUM_PORTS-1:0] oc_change
);
  logic [NUM_PORTS-1:0] charge;
  logic [NUM_PORTS-1:0] oc_trip;
  logic [NUM_PORTS-1:0] pwr_q;
  logic [NUM_PORTS-1:0] lock;
  logic                 cfg_d;
  logic                 cfg_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_d <= 1'b0;
    else        cfg_d <= cfg_done;
  end
  assign cfg_rise = cfg_done & ~cfg_d;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    if (i == 0) begin : g_strap
      assign charge[i] = chg_cfg[i] | chg_strap0;
    end else begin : g_reg
      assign charge[i] = chg_cfg[i];
    end

    ppc_oc_filter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_filt (
      .clk (clk), .rst_n (rst_n), .oc_n (oc_n[i]), .qual (oc_qual),
      .trip(oc_trip[i])
    );

    ppc_port u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .charge_en  (charge[i]),
      .cfg_rise   (cfg_rise),
      .enumerated (enumerated),
      .bus_reset  (bus_reset),
      .host_set   (host_set_pwr[i]),
      .host_clr   (host_clr_pwr[i]),
      .host_clr_oc(host_clr_oc[i]),
      .trip       (oc_trip[i]),
      .pwr_q      (pwr_q[i]),
      .status_q   (oc_status[i]),
      .change_q   (oc_change[i]),
      .lock_q     (lock[i])
    );
  end

  // Power is held at the charge marking while the hardware reset is applied.
  assign pwr_en = rst_n ? pwr_q : charge;
endmodule

// File: rtl/ppc_checks.sv
module ppc_checks #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_reset,
  input logic                 enumerated,
  input logic [NUM_PORTS-1:0] host_set_pwr,
  input logic [NUM_PORTS-1:0] host_clr_pwr,
  input logic [NUM_PORTS-1:0] host_clr_oc,
  input logic [NUM_PORTS-1:0] oc_trip,
  input logic [NUM_PORTS-1:0] lock,
  input logic [NUM_PORTS-1:0] pwr_en,
  input logic [NUM_PORTS-1:0] oc_status,
  input logic [NUM_PORTS-1:0] oc_change
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    // R2
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip[i] |=> !pwr_en[i]);
    // R9
    trip_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip[i] |=> oc_status[i]);
    // R9
    clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_clr_oc[i] && !oc_trip[i]) |=> (!oc_status[i] && !oc_change[i]));
    // R7
    host_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_clr_pwr[i] && !bus_reset) |=> !pwr_en[i]);
    // R3
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_trip[i] && !enumerated) |=> lock[i]);
    // R10
    enum_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enumerated && !bus_reset && !host_set_pwr[i] && !host_clr_pwr[i] && !oc_trip[i])
        |=> $stable(pwr_en[i]));
  end
endmodule

bind port_power_ctrl ppc_checks #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .enumerated(enumerated),
  .host_set_pwr(host_set_pwr), .host_clr_pwr(host_clr_pwr), .host_clr_oc(host_clr_oc),
  .oc_trip(oc_trip), .lock(lock), .pwr_en(pwr_en), .oc_status(oc_status),
  .oc_change(oc_change)
);

// File: tb/port_power_ctrl_tb.sv
module port_power_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, bus_reset = 1'b0, chg_strap0 = 1'b0;
  logic cfg_done = 1'b0, enumerated = 1'b0;
  logic [N-1:0] chg_cfg = '0, host_set_pwr = '0, host_clr_pwr = '0, host_clr_oc = '0;
  logic [N-1:0] oc_n = '1;
  logic [7:0] oc_qual = 8'(L);
  logic [N-1:0] pwr_en, oc_status, oc_change;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_power_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .chg_cfg(chg_cfg),
    .chg_strap0(chg_strap0), .cfg_done(cfg_done), .enumerated(enumerated),
    .host_set_pwr(host_set_pwr), .host_clr_pwr(host_clr_pwr), .host_clr_oc(host_clr_oc),
    .oc_qual(oc_qual), .oc_n(oc_n), .pwr_en(pwr_en), .oc_status(oc_status),
    .oc_change(oc_change)
  );

  // {set, clr, expected power} while enumerated, starting from 00
  localparam logic [5:0] VEC [6] = '{
    {2'b01, 2'b00, 2'b01},
    {2'b10, 2'b00, 2'b11},
    {2'b00, 2'b01, 2'b10},
    {2'b00, 2'b00, 2'b10},
    {2'b01, 2'b01, 2'b10},
    {2'b00, 2'b10, 2'b00}
  };

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_set(input logic [N-1:0] s);
    host_set_pwr = s; tick(1); host_set_pwr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R4, R6: power follows charge marking during reset
    chg_cfg = 2'b10; tick(3);
    chk("R4 reset pwr", pwr_en, 2'b10);
    chg_cfg = 2'b00; chg_strap0 = 1'b1; tick(1);
    chk("R6 strap port0", pwr_en, 2'b01);
    chg_strap0 = 1'b0; tick(2);
    rst_n = 1'b1; tick(1);
    chk("R4 status after reset", oc_status | oc_change, 2'b00);
    chk("R4 pwr after reset", pwr_en, 2'b00);

    // R1: charging port waits for configuration, not enumeration
    chg_cfg = 2'b01; tick(2);
    chk("R1 before cfg", pwr_en, 2'b00);
    cfg_done = 1'b1; tick(1);
    chk("R1 cfg rise", pwr_en, 2'b01);

    // R8: short glitch ignored
    oc_n[0] = 1'b0; tick(L-1); oc_n[0] = 1'b1; tick(6);
    chk("R8 glitch pwr", pwr_en, 2'b01);
    chk("R8 glitch status", oc_status, 2'b00);

    // R2, R9: qualified fault on port 0 only
    pulse_set(2'b10);
    oc_n[0] = 1'b0; tick(L+3);
    chk("R2 fault off", pwr_en, 2'b10);
    chk("R9 status set", oc_status, 2'b01);
    chk("R9 change set", oc_change, 2'b01);
    oc_n[0] = 1'b1; tick(4);

    // R3: lockout against automatic restore
    cfg_done = 1'b0; tick(1); cfg_done = 1'b1; tick(1);
    chk("R3 cfg no restore", pwr_en, 2'b10);
    bus_reset = 1'b1; tick(1); bus_reset = 1'b0;
    chk("R3/R5 bus reset locked", pwr_en, 2'b00);
    pulse_set(2'b01);
    chk("R3 host restore", pwr_en, 2'b01);

    // R9: host clear
    host_clr_oc = 2'b01; tick(1); host_clr_oc = '0;
    chk("R9 clear", oc_status | oc_change, 2'b00);

    // R5: bus reset powers charging, removes others
    pulse_set(2'b10);
    chk("R7 set port1", pwr_en, 2'b11);
    bus_reset = 1'b1; tick(1); bus_reset = 1'b0;
    chk("R5 bus reset", pwr_en, 2'b01);

    // R7, R10: host command table while enumerated
    enumerated = 1'b1;
    host_clr_pwr = 2'b11; tick(1); host_clr_pwr = '0;
    for (int v = 0; v < 6; v++) begin
      host_set_pwr = VEC[v][5:4]; host_clr_pwr = VEC[v][3:2]; tick(1);
      host_set_pwr = '0; host_clr_pwr = '0;
      chk("R7 host vector", pwr_en, VEC[v][1:0]);
    end
    cfg_done = 1'b0; tick(1); cfg_done = 1'b1; chg_cfg = 2'b11; tick(2);
    chk("R10 cfg ignored", pwr_en, 2'b00);

    // R8: zero run length acts as one
    oc_qual = '0; pulse_set(2'b10);
    oc_n[1] = 1'b0; tick(4); oc_n[1] = 1'b1;
    chk("R8 zero run trips", pwr_en, 2'b00);
    chk("R9 status port1", oc_status, 2'b10);
    tick(4);

    // R4: hardware reset clears lockout and status
    enumerated = 1'b0; oc_qual = 8'(L); chg_cfg = 2'b01;
    rst_n = 1'b0; tick(2);
    chk("R4 second reset pwr", pwr_en, 2'b01);
    rst_n = 1'b1; tick(1);
    chk("R4 second reset status", oc_status, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule